// File: doc/BRIEF.md
# Peripheral I/O Port Decoder and Data Buffer Steering

This block sits between an 8-bit CPU I/O bus and a peripheral card. It watches the address byte and the active-low bus control lines. When an I/O access falls inside an eight-port window it produces a chip select for a parallel I/O controller and individual read and write strobes for the registers of a bus interface chip. It also drives the enable and the direction of the bidirectional data buffer between the CPU bus and the card bus.

The buffer is turned toward the CPU for every I/O read in the window. It is also turned toward the CPU during a mode-2 interrupt acknowledge cycle, but only when the card's parallel controller is the device being serviced on the interrupt daisy chain. The CPU can then fetch the interrupt vector from that controller.

All outputs are combinational. The window base and the register offsets are parameters. Their defaults place the card at ports C0H to C7H.

Top module: `iodec_top`

## Requirements
- R1: An I/O access is valid when `iorq_n`=0, `m1_n`=1 and exactly one of `rd_n` and `wr_n` is 0. A valid access to any port C0H..C7H drives `buf_en_n`=0.
- R2: `pio_cs_n`=0 exactly when a valid access targets C0H..C3H (address bit 2 = 0 inside the window), for a read or a write.
- R3: `w1_n`=0 exactly when a valid write targets port C5H.
- R4: `w2_n`=0 exactly when a valid write targets port C4H.
- R5: `r1_n`=0 exactly when a valid read targets port C4H. A write to C4H leaves it at 1.
- R6: `buf_dir`=0 (card to CPU) during a valid read in the window. `buf_dir`=1 (CPU to card) during a valid write in the window and in every idle cycle.
- R7: A vector fetch is an acknowledge cycle (`m1_n`=0, `iorq_n`=0, `rd_n`=1) with `iei`=1 and `ieo`=0. During it, `buf_en_n`=0 and `buf_dir`=0, whatever the address, while the chip select and all strobes stay at 1.
- R8: An acknowledge cycle with `iei`=0 or `ieo`=1 leaves the buffer idle (`buf_en_n`=1, `buf_dir`=1).
- R9: With `iorq_n`=1 the chip select and all strobes are 1 and the buffer is idle, for any other inputs.
- R10: When `rd_n` and `wr_n` are both 0 in an I/O cycle, no strobe or select is issued and the buffer is idle.
- R11: Any I/O access to a port outside C0H..C7H issues no strobe or select and leaves the buffer idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 8 | I/O port address from the CPU's low address byte |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read, active low |
| wr_n | input | 1 | Write, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| iei | input | 1 | Daisy-chain enable into the parallel controller |
| ieo | input | 1 | Daisy-chain enable out of the parallel controller |
| pio_cs_n | output | 1 | Parallel I/O controller chip select, active low |
| w1_n | output | 1 | Interface register write strobe for port C5H, active low |
| w2_n | output | 1 | Interface register write strobe for port C4H, active low |
| r1_n | output | 1 | Interface register read strobe for port C4H, active low |
| buf_en_n | output | 1 | Data buffer enable, active low |
| buf_dir | output | 1 | Buffer direction: 1 CPU to card, 0 card to CPU |

## Verification
Two functions can be active in the same cycle. The register decode may see a window address during an acknowledge cycle, and the vector path then competes with it for the buffer. The bench provokes this with directed acknowledges that carry C0H..C7H addresses, and with random cycles that put IORQ and M1 low together across all daisy-chain states. The outcome passes only if the buffer points to the CPU and no select or strobe leaks out, or, when the chain does not grant this controller, only if the buffer stays idle.

// File: rtl/iodec_pkg.sv
// Package: shared types for the I/O port decoder.
// Assumes an 8-bit I/O address space; windows are aligned to their size.
package iodec_pkg;
    // Kind of bus cycle currently presented by the CPU.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_ACK   = 2'd3
    } cyc_kind_e;

    // Bundle of active-low strobe outputs.
    typedef struct packed {
        logic pio_cs_n;
        logic w1_n;
        logic w2_n;
        logic r1_n;
    } strobes_t;
endpackage

// File: rtl/iodec_cycle.sv
// Module: iodec_cycle
// Classifies the CPU bus cycle and detects a hit in the card's port window.
// Assumes the window base is aligned to 2**OFS_W ports.
module iodec_cycle
    import iodec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 3,
    parameter logic [ADDR_W-1:0] BASE = 8'hC0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              m1_n,
    output cyc_kind_e         kind,
    output logic              win_hit,
    output logic [OFS_W-1:0]  offset
);
    localparam int TAG_W = ADDR_W - OFS_W;

    // Compare the upper address bits against the window base.
    always_comb begin
        win_hit = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
        offset  = addr[OFS_W-1:0];
    end

    // Classify the cycle; a read and a write together count as idle.
    always_comb begin
        kind = CYC_IDLE;
        if (!iorq_n) begin
            if (!m1_n) begin
                if (rd_n) kind = CYC_ACK;
            end else if (!rd_n && wr_n) begin
                kind = CYC_READ;
            end else if (rd_n && !wr_n) begin
                kind = CYC_WRITE;
            end
        end
    end

    // TAG_W only documents the compared span.
    initial begin
        if (TAG_W < 1) $display("iodec_cycle: window covers the whole space");
    end
endmodule

// File: rtl/iodec_strobe.sv
// Module: iodec_strobe
// Produces the controller select and the interface register strobes.
// Assumes the cycle kind and window hit come from iodec_cycle.
module iodec_strobe
    import iodec_pkg::*;
#(
    parameter int OFS_W = 3,
    parameter logic [OFS_W-1:0] W1_OFS = 3'd5,
    parameter logic [OFS_W-1:0] RW_OFS = 3'd4
) (
    input  cyc_kind_e        kind,
    input  logic             win_hit,
    input  logic [OFS_W-1:0] offset,
    output strobes_t         strb
);
    logic acc_rd;
    logic acc_wr;

    // Qualify reads and writes with the window hit.
    always_comb begin
        acc_rd = win_hit && (kind == CYC_READ);
        acc_wr = win_hit && (kind == CYC_WRITE);
    end

    // Drive each active-low strobe from the qualified access and offset.
    always_comb begin
        strb.pio_cs_n = !((acc_rd || acc_wr) && !offset[OFS_W-1]);
        strb.w1_n     = !(acc_wr && (offset == W1_OFS));
        strb.w2_n     = !(acc_wr && (offset == RW_OFS));
        strb.r1_n     = !(acc_rd && (offset == RW_OFS));
    end
endmodule

// File: rtl/iodec_bufctl.sv
// Module: iodec_bufctl
// Steers the data buffer: enable for window accesses and vector fetches,
// direction toward the CPU for reads. Idle state is disabled, CPU-to-card.
module iodec_bufctl
    import iodec_pkg::*;
(
    input  cyc_kind_e kind,
    input  logic      win_hit,
    input  logic      iei,
    input  logic      ieo,
    output logic      buf_en_n,
    output logic      buf_dir
);
    logic vec_fetch;
    logic reg_rd;
    logic reg_wr;

    // Detect the granted vector fetch and the window register accesses.
    always_comb begin
        vec_fetch = (kind == CYC_ACK) && iei && !ieo;
        reg_rd    = win_hit && (kind == CYC_READ);
        reg_wr    = win_hit && (kind == CYC_WRITE);
    end

    // Enable and direction from the detected activity.
    always_comb begin
        buf_en_n = !(vec_fetch || reg_rd || reg_wr);
        buf_dir  = !(vec_fetch || reg_rd);
    end
endmodule

// File: rtl/iodec_top.sv
// Module: iodec_top
// I/O port decoder and buffer control for a peripheral card.
// Purely combinational; assumes active-low bus control inputs.
module iodec_top
    import iodec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 3,
    parameter logic [ADDR_W-1:0] BASE = 8'hC0,
    parameter logic [OFS_W-1:0]  W1_OFS = 3'd5,
    parameter logic [OFS_W-1:0]  RW_OFS = 3'd4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              m1_n,
    input  logic              iei,
    input  logic              ieo,
    output logic              pio_cs_n,
    output logic              w1_n,
    output logic              w2_n,
    output logic              r1_n,
    output logic              buf_en_n,
    output logic              buf_dir
);
    cyc_kind_e        kind;
    logic             win_hit;
    logic [OFS_W-1:0] offset;
    strobes_t         strb;

    iodec_cycle #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BASE(BASE)) u_cycle (
        .addr(addr), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
        .kind(kind), .win_hit(win_hit), .offset(offset)
    );

    iodec_strobe #(.OFS_W(OFS_W), .W1_OFS(W1_OFS), .RW_OFS(RW_OFS)) u_strobe (
        .kind(kind), .win_hit(win_hit), .offset(offset), .strb(strb)
    );

    iodec_bufctl u_buf (
        .kind(kind), .win_hit(win_hit), .iei(iei), .ieo(ieo),
        .buf_en_n(buf_en_n), .buf_dir(buf_dir)
    );

    // Unpack the strobe bundle onto the ports.
    always_comb begin
        pio_cs_n = strb.pio_cs_n;
        w1_n     = strb.w1_n;
        w2_n     = strb.w2_n;
        r1_n     = strb.r1_n;
    end
endmodule

// File: rtl/iodec_checker.sv
// Module: iodec_checker
// Cross-checks strobes against buffer control; bound to iodec_top.
module iodec_checker (
    input logic iorq_n,
    input logic m1_n,
    input logic pio_cs_n,
    input logic w1_n,
    input logic w2_n,
    input logic r1_n,
    input logic buf_en_n,
    input logic buf_dir
);
    // Relate the strobe logic to the buffer logic on every input change.
    always_comb begin
        assert_cs_needs_buf_R2: assert (pio_cs_n || !buf_en_n);
        assert_w1_writes_out_R3: assert (w1_n || (!buf_en_n && buf_dir));
        assert_w2_writes_out_R4: assert (w2_n || (!buf_en_n && buf_dir));
        assert_r1_reads_in_R5: assert (r1_n || (!buf_en_n && !buf_dir));
        assert_idle_dir_R6: assert (!buf_en_n || buf_dir);
        assert_ack_no_strobe_R7: assert (m1_n || (pio_cs_n && w1_n && w2_n && r1_n));
        assert_no_iorq_idle_R9: assert (!iorq_n ||
            (pio_cs_n && w1_n && w2_n && r1_n && buf_en_n && buf_dir));
        assert_one_strobe_R10: assert ($countones({~w1_n, ~w2_n, ~r1_n}) <= 1);
    end
endmodule

bind iodec_top iodec_checker u_chk (
    .iorq_n(iorq_n), .m1_n(m1_n), .pio_cs_n(pio_cs_n), .w1_n(w1_n),
    .w2_n(w2_n), .r1_n(r1_n), .buf_en_n(buf_en_n), .buf_dir(buf_dir)
);

// File: tb/tb_iodec_top.sv
module tb_iodec_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [7:0] addr;
    logic iorq_n, rd_n, wr_n, m1_n, iei, ieo;
    logic pio_cs_n, w1_n, w2_n, r1_n, buf_en_n, buf_dir;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    iodec_top dut (
        .addr(addr), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
        .iei(iei), .ieo(ieo), .pio_cs_n(pio_cs_n), .w1_n(w1_n), .w2_n(w2_n),
        .r1_n(r1_n), .buf_en_n(buf_en_n), .buf_dir(buf_dir)
    );

    // Expected outputs packed {pio_cs_n,w1_n,w2_n,r1_n,buf_en_n,buf_dir}.
    function automatic logic [5:0] model(input logic [7:0] a, input logic io,
        input logic rd, input logic wr, input logic m1, input logic ei, input logic eo);
        logic in_win, v_rd, v_wr, vec;
        in_win = (a[7:3] == 5'b11000);
        v_rd = !io && m1 && !rd && wr && in_win;
        v_wr = !io && m1 && rd && !wr && in_win;
        vec  = !io && !m1 && rd && ei && !eo;
        return { !((v_rd || v_wr) && !a[2]),
                 !(v_wr && a[2:0] == 3'd5),
                 !(v_wr && a[2:0] == 3'd4),
                 !(v_rd && a[2:0] == 3'd4),
                 !(v_rd || v_wr || vec),
                 !(v_rd || vec) };
    endfunction

    // Requirement tag for the situation presented.
    function automatic string tag_of(input logic [7:0] a, input logic io,
        input logic rd, input logic wr, input logic m1, input logic ei, input logic eo);
        if (io) return "R9";
        if (!m1) return (rd && ei && !eo) ? "R7" : "R8";
        if (!rd && !wr) return "R10";
        if (a[7:3] != 5'b11000) return "R11";
        if (!rd) return (a[2:0] == 3'd4) ? "R5" : "R6";
        if (!wr) return (a[2:0] == 3'd5) ? "R3" : ((a[2:0] == 3'd4) ? "R4" : "R2");
        return "R1";
    endfunction

    task automatic apply(input logic [7:0] a, input logic io, input logic rd,
        input logic wr, input logic m1, input logic ei, input logic eo, input string tag);
        logic [5:0] exp, got;
        @(posedge clk);
        #1;
        addr = a; iorq_n = io; rd_n = rd; wr_n = wr; m1_n = m1; iei = ei; ieo = eo;
        #3;
        exp = model(a, io, rd, wr, m1, ei, eo);
        got = {pio_cs_n, w1_n, w2_n, r1_n, buf_en_n, buf_dir};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%02h actual=%06b expected=%06b", tag, a, got, exp);
        end
    endtask

    initial begin
        addr = 8'h00; iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1; iei = 1; ieo = 0;
        // Reset-like idle state (R9).
        apply(8'hC0, 1, 1, 1, 1, 1, 0, "R9");
        // R1/R2: window accesses with select.
        apply(8'hC0, 0, 0, 1, 1, 0, 1, "R2");
        apply(8'hC3, 0, 1, 0, 1, 0, 1, "R2");
        apply(8'hC7, 0, 0, 1, 1, 0, 1, "R1");
        // R3, R4, R5 strobes.
        apply(8'hC5, 0, 1, 0, 1, 0, 1, "R3");
        apply(8'hC4, 0, 1, 0, 1, 0, 1, "R4");
        apply(8'hC4, 0, 0, 1, 1, 0, 1, "R5");
        apply(8'hC5, 0, 0, 1, 1, 0, 1, "R6");
        // R7 vector fetch with a window address, R8 denied chain.
        apply(8'hC4, 0, 1, 1, 0, 1, 0, "R7");
        apply(8'hC0, 0, 1, 1, 0, 0, 0, "R8");
        apply(8'hC5, 0, 1, 1, 0, 1, 1, "R8");
        // R9 with strobes low, R10 conflict, R11 outside window.
        apply(8'hC4, 1, 0, 1, 1, 1, 0, "R9");
        apply(8'hC4, 0, 0, 0, 1, 1, 0, "R10");
        apply(8'hBF, 0, 0, 1, 1, 1, 0, "R11");
        apply(8'hC8, 0, 1, 0, 1, 1, 0, "R11");
        // Constrained random, biased toward the window and bus cycles.
        void'($urandom(32'h0C0FFEE5));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic io, rd, wr, m1, ei, eo;
            a  = ($urandom % 4 != 0) ? (8'hC0 | 8'($urandom % 8)) : 8'($urandom);
            io = ($urandom % 5 == 0);
            rd = $urandom % 2; wr = ($urandom % 4 == 0) ? rd : !rd;
            m1 = ($urandom % 4 != 0);
            ei = $urandom % 2; eo = $urandom % 2;
            apply(a, io, rd, wr, m1, ei, eo, tag_of(a, io, rd, wr, m1, ei, eo));
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule